// File: doc/BRIEF.md
# Stuck-at and Bridging Fault Injection Harness for a NAND-Built XOR

The block holds two copies of an exclusive-OR built from four two-input NAND gates. One copy is always fault-free. In the other, exactly one chosen line can be pinned to a constant, or two chosen lines can be shorted together. Both copies see the same two data bits. The block registers both results and raises an error flag whenever the two results differ. It serves as a small, deterministic target for checking test vectors, fault dictionaries and fault-coverage reasoning against real gate behaviour.

Every fanout branch counts as its own fault site, separate from its stem, so the network has twelve lines and twenty-four single stuck-at faults. The comparison uses only the two network outputs. A fault can therefore be active without producing an error: either the pinned value already equals the fault-free value, or a controlling value further down the path hides it. In bridging mode both shorted lines take the AND of the two values their drivers would produce in the fault-free network when wired-AND is selected, and the OR of those values when wired-OR is selected.

Top module: `xor_fault_harness`

## Requirements
- R1: While `rst` is high at a rising clock edge, `good_q`, `bad_q` and `err_q` are all 0 after that edge.
- R2: All outputs are registered. One clock after the inputs are applied, `good_q` equals `in_a XOR in_b`.
- R3: With `flt_en` and `bridge_en` both low, `bad_q` equals `good_q` and `err_q` is 0, whatever values `site_idx`, `stuck_val`, `br_x` and `br_y` hold.
- R4: The site numbers are 0 = a, 1 = b, 2 = branch of a into the first NAND, 3 = branch of a into the second NAND, 4 = branch of b into the first NAND, 5 = branch of b into the third NAND, 6 = first NAND output, 7 = its branch into the second NAND, 8 = its branch into the third NAND, 9 = second NAND output, 10 = third NAND output, 11 = final NAND output z.
- R5: With `flt_en` high and `bridge_en` low, the line at `site_idx` is held at `stuck_val`, and all other lines are left untouched. `bad_q` is the resulting faulty output, and `err_q` is 1 exactly when `bad_q` differs from `good_q`.
- R6: A fault whose pinned value equals the fault-free value, or whose effect is blocked by a controlling value, leaves `err_q` at 0.
- R7: A `site_idx` from 12 to 15 injects no fault.
- R8: With `bridge_en` high and `bridge_or` low, lines `br_x` and `br_y` both carry the AND of their fault-free values.
- R9: With `bridge_en` high and `bridge_or` high, lines `br_x` and `br_y` both carry the OR of their fault-free values.
- R10: A bridge whose two indices are equal, or whose index is 12 or above, injects no fault.
- R11: When `bridge_en` is high, `flt_en`, `site_idx` and `stuck_val` have no effect.
- R12: Each of the 24 single stuck-at faults raises `err_q` for at least one of the four input patterns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_a | input | 1 | Data bit a |
| in_b | input | 1 | Data bit b |
| flt_en | input | 1 | Enable single stuck-at injection |
| site_idx | input | 4 | Stuck-at site number (R4 encoding) |
| stuck_val | input | 1 | Constant the stuck line is held at |
| bridge_en | input | 1 | Enable bridging short (takes priority) |
| bridge_or | input | 1 | 0 = wired-AND short, 1 = wired-OR short |
| br_x | input | 4 | First shorted line number |
| br_y | input | 4 | Second shorted line number |
| good_q | output | 1 | Registered fault-free result |
| bad_q | output | 1 | Registered faulty-copy result |
| err_q | output | 1 | Registered mismatch flag |

## Verification
The bench compares every one of the 24 stuck-at faults under all four input patterns against a hand-derived dictionary of detecting vectors. A site number that is shifted, or a branch that is merged into its stem, shows up as an error flag in the wrong cell of that dictionary. Masked cases are tested specifically. Examples are z stuck-at-0 under pattern 00, and a middle NAND stuck-at-1 where the other middle NAND is also 1. A design that compares internal lines, or that ignores masking, would flag errors in these cases. Bridges are checked for both wired functions, including a wired-AND short that hides itself. Further checks cover out-of-range and equal indices, and the priority of bridging over stuck-at injection. A design with the wrong priority, or one that decodes indices 12 to 15 as real sites, would raise a spurious error.

// File: rtl/xfh_pkg.sv
package xfh_pkg;
  localparam int N_SITE = 12;
  localparam int IDX_W  = 4;
  localparam int SITE_Z = 11;
  typedef logic [N_SITE-1:0] line_vec_t;
endpackage

// File: rtl/xfh_site_decode.sv
module xfh_site_decode
  import xfh_pkg::*;
(
  input  line_vec_t              good_lines,
  input  logic                   flt_en,
  input  logic [IDX_W-1:0]       site_idx,
  input  logic                   stuck_val,
  input  logic                   bridge_en,
  input  logic                   bridge_or,
  input  logic [IDX_W-1:0]       br_x,
  input  logic [IDX_W-1:0]       br_y,
  output line_vec_t              frc_mask,
  output line_vec_t              frc_val
);
  localparam logic [IDX_W-1:0] LIM = IDX_W'(N_SITE);

  logic px, py, wired, br_ok, sa_ok;

  // fault-free values of the two shorted lines
  always_comb begin
    px = 1'b0;
    py = 1'b0;
    for (int i = 0; i < N_SITE; i++) begin
      if (br_x == IDX_W'(i)) px = good_lines[i];
      if (br_y == IDX_W'(i)) py = good_lines[i];
    end
  end

  assign wired = bridge_or ? (px | py) : (px & py);
  assign br_ok = bridge_en && (br_x < LIM) && (br_y < LIM) && (br_x != br_y);
  assign sa_ok = !bridge_en && flt_en && (site_idx < LIM);

  always_comb begin
    frc_mask = '0;
    frc_val  = '0;
    for (int i = 0; i < N_SITE; i++) begin
      if (br_ok && (br_x == IDX_W'(i) || br_y == IDX_W'(i))) begin
        frc_mask[i] = 1'b1;
        frc_val[i]  = wired;
      end else if (sa_ok && site_idx == IDX_W'(i)) begin
        frc_mask[i] = 1'b1;
        frc_val[i]  = stuck_val;
      end
    end
  end
endmodule

// File: rtl/xfh_nand_net.sv
module xfh_nand_net
  import xfh_pkg::*;
(
  input  logic      in_a,
  input  logic      in_b,
  input  line_vec_t frc_mask,
  input  line_vec_t frc_val,
  output line_vec_t lines
);
  function automatic logic tap(input logic drv, input logic m, input logic v);
    return m ? v : drv;
  endfunction

  logic a_s, b_s, a_n1, a_n2, b_n1, b_n3;
  logic n1, n1_n2, n1_n3, n2, n3, z;

  assign a_s   = tap(in_a,            frc_mask[0],  frc_val[0]);
  assign b_s   = tap(in_b,            frc_mask[1],  frc_val[1]);
  assign a_n1  = tap(a_s,             frc_mask[2],  frc_val[2]);
  assign a_n2  = tap(a_s,             frc_mask[3],  frc_val[3]);
  assign b_n1  = tap(b_s,             frc_mask[4],  frc_val[4]);
  assign b_n3  = tap(b_s,             frc_mask[5],  frc_val[5]);
  assign n1    = tap(~(a_n1 & b_n1),  frc_mask[6],  frc_val[6]);
  assign n1_n2 = tap(n1,              frc_mask[7],  frc_val[7]);
  assign n1_n3 = tap(n1,              frc_mask[8],  frc_val[8]);
  assign n2    = tap(~(a_n2 & n1_n2), frc_mask[9],  frc_val[9]);
  assign n3    = tap(~(n1_n3 & b_n3), frc_mask[10], frc_val[10]);
  assign z     = tap(~(n2 & n3),      frc_mask[11], frc_val[11]);

  assign lines = {z, n3, n2, n1_n3, n1_n2, n1, b_n3, b_n1, a_n2, a_n1, b_s, a_s};
endmodule

// File: rtl/xor_fault_harness.sv
module xor_fault_harness
  import xfh_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_a,
  input  logic             in_b,
  input  logic             flt_en,
  input  logic [IDX_W-1:0] site_idx,
  input  logic             stuck_val,
  input  logic             bridge_en,
  input  logic             bridge_or,
  input  logic [IDX_W-1:0] br_x,
  input  logic [IDX_W-1:0] br_y,
  output logic             good_q,
  output logic             bad_q,
  output logic             err_q
);
  line_vec_t good_lines, bad_lines, frc_mask, frc_val;

  xfh_nand_net u_good (
    .in_a(in_a), .in_b(in_b),
    .frc_mask('0), .frc_val('0),
    .lines(good_lines)
  );

  xfh_site_decode u_dec (
    .good_lines(good_lines), .flt_en(flt_en), .site_idx(site_idx),
    .stuck_val(stuck_val), .bridge_en(bridge_en), .bridge_or(bridge_or),
    .br_x(br_x), .br_y(br_y), .frc_mask(frc_mask), .frc_val(frc_val)
  );

  xfh_nand_net u_bad (
    .in_a(in_a), .in_b(in_b),
    .frc_mask(frc_mask), .frc_val(frc_val),
    .lines(bad_lines)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      good_q <= 1'b0;
      bad_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      good_q <= good_lines[SITE_Z];
      bad_q  <= bad_lines[SITE_Z];
      err_q  <= good_lines[SITE_Z] ^ bad_lines[SITE_Z];
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!good_q && !bad_q && !err_q));

  p_good_xor_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (good_q == ($past(in_a) ^ $past(in_b))));

  p_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (!flt_en && !bridge_en) |=> (bad_q == good_q && !err_q));

  p_copies_agree_r3: assert property (@(posedge clk) disable iff (rst)
    (frc_mask == '0) |-> (bad_lines == good_lines));

  p_single_site_r5: assert property (@(posedge clk) disable iff (rst)
    !bridge_en |-> $onehot0(frc_mask));

  p_no_site_r7: assert property (@(posedge clk) disable iff (rst)
    (flt_en && !bridge_en && site_idx >= IDX_W'(N_SITE)) |=> !err_q);

  p_pair_only_r8: assert property (@(posedge clk) disable iff (rst)
    $countones(frc_mask) <= 2);
endmodule

// File: tb/xor_fault_harness_test.sv
module xor_fault_harness_test;
  localparam int CLK_PERIOD = 10;

  // detecting patterns per fault: index = site*2 + stuck value,
  // bit p set when input pattern p = {a,b} exposes the fault
  localparam logic [3:0] DET_TBL [24] = '{
    4'b1100, 4'b0011,  4'b1010, 4'b0101,
    4'b1000, 4'b0010,  4'b0100, 4'b0001,
    4'b1000, 4'b0100,  4'b0010, 4'b0001,
    4'b0110, 4'b1000,  4'b0100, 4'b1000,
    4'b0010, 4'b1000,  4'b1001, 4'b0100,
    4'b1001, 4'b0010,  4'b0110, 4'b1001
  };

  logic clk = 1'b0, rst = 1'b1;
  logic in_a = 0, in_b = 0, flt_en = 0, stuck_val = 0, bridge_en = 0, bridge_or = 0;
  logic [3:0] site_idx = 0, br_x = 0, br_y = 0;
  logic good_q, bad_q, err_q;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xor_fault_harness uut (
    .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b), .flt_en(flt_en),
    .site_idx(site_idx), .stuck_val(stuck_val), .bridge_en(bridge_en),
    .bridge_or(bridge_or), .br_x(br_x), .br_y(br_y),
    .good_q(good_q), .bad_q(bad_q), .err_q(err_q)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic a, input logic b, input logic fe, input logic [3:0] s,
                       input logic sv, input logic be, input logic bo,
                       input logic [3:0] x, input logic [3:0] y);
    @(negedge clk);
    in_a = a; in_b = b; flt_en = fe; site_idx = s; stuck_val = sv;
    bridge_en = be; bridge_or = bo; br_x = x; br_y = y;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset good", good_q, 1'b0);
    chk("R1 reset bad",  bad_q,  1'b0);
    chk("R1 reset err",  err_q,  1'b0);
    rst = 1'b0;

    // R2/R3: no fault, junk on fault controls
    for (int p = 0; p < 4; p++) begin
      drive(p[1], p[0], 1'b0, 4'd6, p[0], 1'b0, 1'b1, 4'd0, 4'd1);
      chk("R2 xor", good_q, p[1] ^ p[0]);
      chk("R3 bad eq good", bad_q, p[1] ^ p[0]);
      chk("R3 no err", err_q, 1'b0);
    end

    // R4/R5/R6/R12: full stuck-at dictionary walk
    for (int f = 0; f < 24; f++) begin
      logic seen;
      seen = 1'b0;
      for (int p = 0; p < 4; p++) begin
        logic det;
        det = DET_TBL[f][p];
        drive(p[1], p[0], 1'b1, 4'(f / 2), f[0], 1'b0, 1'b0, 4'd0, 4'd0);
        if (det) chk("R5 detect err", err_q, 1'b1);
        else     chk("R6 masked err", err_q, 1'b0);
        chk("R4 site faulty z", bad_q, (p[1] ^ p[0]) ^ det);
        seen = seen | err_q;
      end
      chk("R12 fault detectable", seen, 1'b1);
    end

    // R7: indices 12..15 inject nothing
    for (int s = 12; s < 16; s++) begin
      for (int p = 0; p < 4; p++) begin
        drive(p[1], p[0], 1'b1, 4'(s), ~(p[1] ^ p[0]), 1'b0, 1'b0, 4'd0, 4'd0);
        chk("R7 no fault err", err_q, 1'b0);
      end
    end

    // R8: wired-AND of a and b, pattern 01 -> z 0
    drive(1'b0, 1'b1, 1'b0, 4'd0, 1'b0, 1'b1, 1'b0, 4'd0, 4'd1);
    chk("R8 and a-b bad", bad_q, 1'b0);
    chk("R8 and a-b err", err_q, 1'b1);
    // R8: wired-AND of middle NANDs, pattern 01 -> self-masked
    drive(1'b0, 1'b1, 1'b0, 4'd0, 1'b0, 1'b1, 1'b0, 4'd9, 4'd10);
    chk("R8 and mid err", err_q, 1'b0);
    // R9: wired-OR of a and b, pattern 10 -> z 0
    drive(1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 1'b1, 1'b1, 4'd0, 4'd1);
    chk("R9 or a-b bad", bad_q, 1'b0);
    chk("R9 or a-b err", err_q, 1'b1);
    // R9: wired-OR of middle NANDs, pattern 01 -> z 0
    drive(1'b0, 1'b1, 1'b0, 4'd0, 1'b0, 1'b1, 1'b1, 4'd10, 4'd9);
    chk("R9 or mid err", err_q, 1'b1);
    // R10: equal or out-of-range indices
    drive(1'b0, 1'b1, 1'b0, 4'd0, 1'b0, 1'b1, 1'b0, 4'd1, 4'd1);
    chk("R10 equal idx err", err_q, 1'b0);
    drive(1'b0, 1'b1, 1'b0, 4'd0, 1'b0, 1'b1, 1'b0, 4'd1, 4'd13);
    chk("R10 range idx err", err_q, 1'b0);
    // R11: inactive bridge still blocks stuck-at z sa1 under 00
    drive(1'b0, 1'b0, 1'b1, 4'd11, 1'b1, 1'b1, 1'b0, 4'd3, 4'd3);
    chk("R11 priority bad", bad_q, 1'b0);
    chk("R11 priority err", err_q, 1'b0);

    // R1: reset while a fault is flagging
    drive(1'b0, 1'b0, 1'b1, 4'd11, 1'b1, 1'b0, 1'b0, 4'd0, 4'd0);
    chk("R5 pre-reset err", err_q, 1'b1);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 mid reset err", err_q, 1'b0);
    chk("R1 mid reset bad", bad_q, 1'b0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule